// File: doc/BRIEF.md
# Prioritized Interrupt Mask and Source Controller

This block gathers interrupt and wake-up events from a set of functional groups. The groups are a high-side driver, a low-side driver, a LIN transceiver, a voltage monitor and the wake-up logic. The block signals all of them to a host through one active-low interrupt line. Every event latches a pending flag of its own. A four-bit write-only mask decides which of the maskable flags may pull the line low. Four sources ignore the mask completely: stop-mode wake-up, LIN wake-up, low voltage or regulator over-temperature, and forced wake-up.

The host reads a four-bit source code that names the highest-priority pending flag. That read also acknowledges the flag. When other enabled flags are still waiting after an acknowledge, the line is released for a fixed window of about 10 µs and then pulled low again. This window lets an edge-triggered host see a fresh edge. A mask write puts the current source code on the read-data path without acknowledging anything. Register access uses a plain write strobe and read strobe, so a serial command front end can sit in front of the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four mask bits are 1 and no flag is pending. `irq_n` is 1 and `rd_data` is 0.
- R2: A one-cycle event pulse latches its flag. A read returns the code of that source: stop wake 1, high-side over-temperature 2, low-side over-temperature 3, LIN wake 4, LIN fault 5, low voltage/regulator over-temperature 6, over-voltage 7, forced wake 8. Code 0 means nothing is pending.
- R3: With several flags pending, successive reads return their codes in ascending code order, code 1 first. After the last flag has been read, a read returns 0.
- R4: A read clears only the flag whose code it returns. The flags that are still pending are reported by later reads.
- R5: Mask bits are `wr_data[3]` high-side, `[2]` low-side, `[1]` LIN fault, `[0]` over-voltage, with 1 meaning enabled. A masked source still latches and is still reported by reads, but it leaves `irq_n` high.
- R6: Codes 1, 4, 6 and 8 drive `irq_n` low even when all mask bits are 0. The voltage-monitor mask bit affects only code 7.
- R7: A mask write places the current source code on `rd_data` one cycle later. It clears no flag.
- R8: If no enabled flag is left after a read, `irq_n` is 1 in the cycle after the read.
- R9: If an enabled flag is still left after a read, `irq_n` stays 1 for exactly `CLK_FREQ_HZ/100000` cycles after the read and then goes low.
- R10: If an event arrives in the same cycle as the read that acknowledges its own flag, the flag stays set.
- R11: `rd_data` changes only in the cycle after a read or a mask write, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 4 | New mask value |
| rd_en | input | 1 | Source read strobe, also acknowledges |
| rd_data | output | 4 | Registered source code |
| ev_stop_wake | input | 1 | Wake-up from stop mode event |
| ev_hs_ot | input | 1 | High-side over-temperature event |
| ev_ls_ot | input | 1 | Low-side over-temperature event |
| ev_lin_wake | input | 1 | LIN wake-up event |
| ev_lin_fault | input | 1 | LIN fault event |
| ev_vm_low | input | 1 | Low voltage or regulator over-temperature event |
| ev_vm_over | input | 1 | Supply over-voltage event |
| ev_forced_wake | input | 1 | Forced wake-up event |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, and that the event inputs are single-cycle pulses sampled on the clock. They also assume that every input is known once reset is released. The directed bench drives every strobe and event for exactly one cycle, starting at a falling edge, and it never issues a write and a read together. The only place where an event overlaps a strobe is the collision scenario, and there the event overlaps a read on purpose.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants and types for the interrupt controller.
// Assumes sources are indexed in priority order, index 0 highest.
package irq_prio_pkg;
    localparam int NUM_SRC   = 8;
    localparam int CODE_W    = 4;
    localparam int MASK_W    = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [CODE_W-1:0]  code_t;

    // Source indices; code reported = index + 1
    localparam int SRC_STOP_WAKE   = 0;
    localparam int SRC_HS_OT       = 1;
    localparam int SRC_LS_OT       = 2;
    localparam int SRC_LIN_WAKE    = 3;
    localparam int SRC_LIN_FAULT   = 4;
    localparam int SRC_VM_LOW      = 5;
    localparam int SRC_VM_OVER     = 6;
    localparam int SRC_FORCED_WAKE = 7;

    // Sources that ignore the mask register
    localparam src_vec_t ALWAYS_ON = src_vec_t'((1 << SRC_STOP_WAKE) | (1 << SRC_LIN_WAKE)
                                     | (1 << SRC_VM_LOW) | (1 << SRC_FORCED_WAKE));
endpackage

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Holds one sticky pending flag per source. A flag sets on its event and
// clears when the matching clear bit is high, with set winning over clear.
// Assumes events are synchronous to clk.
module irq_pend_bank
    import irq_prio_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Latch event, drop on clear unless a new event arrives together
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (evt[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end

        // R2
        evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend[i]);
        // R4
        clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !evt[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Picks the lowest-index pending source and reports its code (index+1)
// plus a one-hot vector of the winner. Purely combinational.
module irq_prio_enc
    import irq_prio_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    output logic [W-1:0] code,
    output logic [N-1:0] win
);
    // Scan from lowest priority up so the highest priority wins last
    always_comb begin
        code = '0;
        win  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code = W'(i + 1);
                win  = N'(1) << i;
            end
        end
    end

    // R2
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) == (pend == '0));
    // R3
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win) && ((win & ~pend) == '0));
endmodule

// File: rtl/irq_release_timer.sv
// Module: irq_release_timer
// Counts the fixed window during which the interrupt line is released after
// an acknowledge that leaves work behind. Loading 0 cancels a window.
module irq_release_timer #(
    parameter int CYCLES = 2500,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic arm,
    output logic active
);
    logic [CW-1:0] cnt;

    // Load window length on arm, cancel on a plain load, else count down
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= arm ? CW'(CYCLES) : '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    // R9
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && arm) |=> active);
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: irq_prio_ctrl (top)
// Mask register, pending flags, priority encoder and release timer. Drives
// an active-low interrupt and returns the source code on reads and on mask
// writes. Assumes wr_en and rd_en are never high together.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 250_000_000,
    localparam int REL_CYCLES  = CLK_FREQ_HZ / 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [CODE_W-1:0] rd_data,
    input  logic              ev_stop_wake,
    input  logic              ev_hs_ot,
    input  logic              ev_ls_ot,
    input  logic              ev_lin_wake,
    input  logic              ev_lin_fault,
    input  logic              ev_vm_low,
    input  logic              ev_vm_over,
    input  logic              ev_forced_wake,
    output logic              irq_n
);
    logic [MASK_W-1:0] mask_q;
    src_vec_t          evt, pend, win, clr, en, remain;
    code_t             code;
    logic              rel_active;

    assign evt = {ev_forced_wake, ev_vm_over, ev_vm_low, ev_lin_fault,
                  ev_lin_wake, ev_ls_ot, ev_hs_ot, ev_stop_wake};

    // Per-source enable: always-on sources or their group mask bit
    always_comb begin
        en = ALWAYS_ON;
        en[SRC_HS_OT]     = mask_q[3];
        en[SRC_LS_OT]     = mask_q[2];
        en[SRC_LIN_FAULT] = mask_q[1];
        en[SRC_VM_OVER]   = mask_q[0];
    end

    // Mask register, all groups enabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (wr_en)  mask_q <= wr_data;
    end

    // Read data path: capture current code on read or mask write
    always_ff @(posedge clk) begin
        if (!rst_n)               rd_data <= '0;
        else if (rd_en || wr_en)  rd_data <= code;
    end

    assign clr    = rd_en ? win : '0;
    assign remain = ((pend & ~clr) | evt) & en;

    irq_pend_bank #(.N(NUM_SRC)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .clr  (clr),
        .pend (pend)
    );

    irq_prio_enc #(.N(NUM_SRC), .W(CODE_W)) u_enc (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend),
        .code (code),
        .win  (win)
    );

    irq_release_timer #(.CYCLES(REL_CYCLES)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_en),
        .arm   (|remain),
        .active(rel_active)
    );

    // Interrupt line low when an enabled flag waits outside a release window
    assign irq_n = !((|(pend & en)) && !rel_active);

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> irq_n);
    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mask_q == $past(wr_data));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> $stable(rd_data));
    // R6
    always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ALWAYS_ON) != '0 && !rel_active) |-> !irq_n);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam int REL = 2500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic [7:0] ev = '0;
    logic       irq_n;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .ev_stop_wake(ev[0]), .ev_hs_ot(ev[1]), .ev_ls_ot(ev[2]),
        .ev_lin_wake(ev[3]), .ev_lin_fault(ev[4]), .ev_vm_low(ev[5]),
        .ev_vm_over(ev[6]), .ev_forced_wake(ev[7]), .irq_n(irq_n)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(logic [7:0] v);
        @(negedge clk); ev = v;
        @(negedge clk); ev = '0;
    endtask

    task automatic rd(output logic [3:0] v);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    task automatic wr(logic [3:0] m);
        @(negedge clk); wr_en = 1'b1; wr_data = m;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic drain();
        logic [3:0] v;
        for (int i = 0; i < 10; i++) rd(v);
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 rd_data", rd_data, 0);
        // mask reset to 1: high-side event must assert line
        pulse(8'h02);
        chk("R1 mask reset enables", irq_n, 0);
        drain();
    endtask

    task automatic t_codes();
        logic [3:0] v;
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1 << i));
            rd(v);
            chk("R2 code", v, i + 1);
            rd(v);
            chk("R2 empty code", v, 0);
        end
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_priority();
        logic [3:0] v;
        pulse(8'hFF);
        for (int i = 1; i <= 8; i++) begin
            rd(v);
            chk("R3 order", v, i);
        end
        rd(v);
        chk("R3 done", v, 0);
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_partial_ack();
        logic [3:0] v;
        pulse(8'h44);     // low-side (3) and over-voltage (7)
        rd(v);
        chk("R4 first", v, 3);
        rd(v);
        chk("R4 remaining", v, 7);
        rd(v);
        chk("R4 cleared", v, 0);
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_mask();
        logic [3:0] v;
        wr(4'b0111);      // high-side disabled
        pulse(8'h02);
        @(negedge clk);
        chk("R5 masked line", irq_n, 1);
        rd(v);
        chk("R5 masked still pending", v, 2);
        wr(4'b0000);
        pulse(8'h40);     // over-voltage masked
        @(negedge clk);
        chk("R6 vm mask hits over-voltage", irq_n, 1);
        pulse(8'h20);     // low voltage always on
        chk("R6 low voltage unmaskable", irq_n, 0);
        rd(v);
        chk("R6 code 6 first", v, 6);
        chk("R8 line high no enabled left", irq_n, 1);
        @(negedge clk);
        chk("R8 line stays high", irq_n, 1);
        rd(v);
        chk("R6 code 7", v, 7);
        for (int i = 0; i < 8; i = i + 1) begin
            if (i == 0 || i == 3 || i == 5 || i == 7) begin
                pulse(8'(1 << i));
                chk("R6 always-on source", irq_n, 0);
                rd(v);
                chk("R6 always-on code", v, i + 1);
            end
        end
        wr(4'b1111);
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_wr_return();
        logic [3:0] v;
        pulse(8'h04);
        wr(4'b1111);
        chk("R7 write returns code", rd_data, 3);
        repeat (3) @(negedge clk);
        chk("R11 rd_data holds", rd_data, 3);
        rd(v);
        chk("R7 no ack on write", v, 3);
        rd(v);
        chk("R7 after ack", v, 0);
        repeat (REL + 2) @(negedge clk);
    endtask

    task automatic t_release();
        logic [3:0] v;
        pulse(8'h06);     // high-side and low-side, both enabled
        chk("R9 line low", irq_n, 0);
        rd(v);
        chk("R9 code", v, 2);
        chk("R9 released", irq_n, 1);
        repeat (REL - 1) @(negedge clk);
        chk("R9 still released at end", irq_n, 1);
        @(negedge clk);
        chk("R9 reasserted", irq_n, 0);
        rd(v);
        chk("R9 second code", v, 3);
        repeat (5) @(negedge clk);
        chk("R8 high after last", irq_n, 1);
    endtask

    task automatic t_collide();
        logic [3:0] v;
        pulse(8'h80);
        @(negedge clk); rd_en = 1'b1; ev = 8'h80;
        @(negedge clk); rd_en = 1'b0; ev = '0; v = rd_data;
        chk("R10 read code", v, 8);
        rd(v);
        chk("R10 flag kept", v, 8);
        rd(v);
        chk("R10 then clear", v, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_codes();
        t_priority();
        t_partial_ack();
        t_mask();
        t_wr_return();
        t_release();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150_000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule